// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside the control logic of a small 8-bit processor and decides when an interrupt service sequence may begin. It accepts a raw, asynchronous request pin and a synchronous timer tick. Either one raises a single pending request. The request is serviced only at an instruction boundary, which the core signals with a one-cycle retire strobe, and only while the global enable is set.

On entry the block takes over a byte-wide stack port for three cycles. It writes the return address, high byte first, then the low byte, then the flags. It then loads the fixed service address into the program counter. Entry clears the global enable, so a handler is never interrupted. A return command runs the same steps in reverse. It reads the flags and both address bytes back, restores the program counter and the flags in one cycle, and sets the enable again. The block owns the stack pointer used by these transfers. While `busy_o` is high the core holds off its own sequencing.

Top module: `irq_entry_seq`

## Requirements
- R1: The request pin passes through SYNC_STAGES (default 2) flip-flops. Only a low-to-high change of the synchronized level counts as an event. With the default, a pin that rises just before clock edge 1 makes the request pending at edge 3. A level held high gives no further event.
- R2: A synchronized rising edge or a high `tick_i` in any cycle sets the pending request. It stays set until an entry starts.
- R3: An entry starts at a clock edge only when all of these hold: the sequencer is idle, `retire_i` is high, a request is pending, the enable is 1, and `rti_i` is low. Without `retire_i`, the block stays idle however long the request waits.
- R4: In the three cycles after the entry edge, `stk_we_o` is high and the port writes PC[15:8], then PC[7:0], then the flags. These are the values present on `pc_i` and `flags_i` at the entry edge. The writes go to addresses SP-1, SP-2 and SP-3, because the pointer drops by one before each write.
- R5: In the cycle after the flags write, `pc_load_o` is high with `pc_value_o` = VECTOR (default 16'hFFF0). In the next cycle `busy_o` is low.
- R6: The entry edge clears the enable, even if `ie_set_i` is high in that cycle.
- R7: While idle, `ie_set_i` sets the enable and `ie_clr_i` clears it. If both are high, the clear wins.
- R8: An `rti_i` pulse while idle starts three read cycles with `stk_re_o` high, at addresses SP, SP+1 and SP+2. The bytes read are taken as flags, PC[7:0] and PC[15:8], and the pointer rises by one after each read. In the fourth cycle, `pc_load_o` and `flags_load_o` are both high and carry the restored values.
- R9: The enable is 1 from the cycle after the restore cycle.
- R10: A request event in the same cycle as the entry edge leaves the request pending, so a second entry follows the return.
- R11: `retire_i` and `rti_i` have no effect while `busy_o` is high.
- R12: After reset the sequencer is idle and the enable is 0. No request is pending, the stack port and the load strobes are low, and the stack pointer equals SP_INIT (default 0, so the first write goes to address 8'hFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin_i | input | 1 | Raw asynchronous interrupt request |
| tick_i | input | 1 | Synchronous timer tick, one cycle per event |
| retire_i | input | 1 | Instruction-retired strobe |
| rti_i | input | 1 | Return-from-interrupt command |
| ie_set_i | input | 1 | Software set of the global enable |
| ie_clr_i | input | 1 | Software clear of the global enable |
| pc_i | input | 16 | Current program counter (return address) |
| flags_i | input | 8 | Current flags register |
| stk_rdata_i | input | 8 | Stack read data, valid in the cycle of the read |
| stk_we_o | output | 1 | Stack write strobe |
| stk_re_o | output | 1 | Stack read strobe |
| stk_addr_o | output | SP_W | Stack byte address |
| stk_wdata_o | output | 8 | Stack write data |
| pc_load_o | output | 1 | Program counter load strobe |
| pc_value_o | output | 16 | Value to load into the program counter |
| flags_load_o | output | 1 | Flags register load strobe |
| flags_value_o | output | 8 | Restored flags value |
| ie_o | output | 1 | Current global enable |
| busy_o | output | 1 | Entry or return sequence in progress |

## Verification
Two functions can act in the same cycle. An entry can start while a new request arrives, and an entry can start while software sets the enable. The bench drives `tick_i` and `ie_set_i` high in the same cycle as the retire strobe that starts an entry. It then judges both outcomes at the ports. The enable must read 0 during the pushes. After the return, a single retire must start a second entry at once with no new request. A return command given in the middle of a push sequence is the third overlap. It must leave the write order and the vector load unchanged.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_PUSH_FL,
        ST_VECTOR,
        ST_POP_FL,
        ST_POP_LO,
        ST_POP_HI,
        ST_RESTORE
    } seq_state_e;

    typedef struct packed {
        logic [15:0] pc;
        logic [7:0]  flags;
    } cpu_ctx_t;

    function automatic logic is_push(input seq_state_e s);
        return (s == ST_PUSH_HI) || (s == ST_PUSH_LO) || (s == ST_PUSH_FL);
    endfunction

    function automatic logic is_pop(input seq_state_e s);
        return (s == ST_POP_FL) || (s == ST_POP_LO) || (s == ST_POP_HI);
    endfunction

endpackage

// File: rtl/irq_req_sync.sv
module irq_req_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic rise_o
);
    localparam int N = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    logic [N-1:0] chain_q;
    logic         last_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b0;
        else     chain_q[0] <= pin_i;
    end

    for (genvar g = 1; g < N; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain_q[g] <= 1'b0;
            else     chain_q[g] <= chain_q[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain_q[N-1];
    end

    assign rise_o = chain_q[N-1] & ~last_q;

    // R1: an edge event lasts one cycle only
    p_single_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/irq_pending_ctl.sv
module irq_pending_ctl (
    input  logic clk,
    input  logic rst,
    input  logic rise_i,
    input  logic tick_i,
    input  logic take_i,
    input  logic restore_i,
    input  logic ie_set_i,
    input  logic ie_clr_i,
    output logic pending_o,
    output logic ie_o
);
    logic event_w;
    assign event_w = rise_i | tick_i;

    always_ff @(posedge clk) begin
        if (rst) pending_o <= 1'b0;
        else     pending_o <= (pending_o & ~take_i) | event_w;
    end

    always_ff @(posedge clk) begin
        if (rst)            ie_o <= 1'b0;
        else if (take_i)    ie_o <= 1'b0;
        else if (restore_i) ie_o <= 1'b1;
        else if (ie_clr_i)  ie_o <= 1'b0;
        else if (ie_set_i)  ie_o <= 1'b1;
    end

    // R2, R10: an event always leaves a pending request behind
    p_event_pends_r2: assert property (@(posedge clk) disable iff (rst)
        event_w |=> pending_o);

    // R2: without an event the request is consumed by entry
    p_take_clears_r2: assert property (@(posedge clk) disable iff (rst)
        (take_i && !event_w) |=> !pending_o);

    // R6: entry always drops the enable
    p_entry_masks_r6: assert property (@(posedge clk) disable iff (rst)
        take_i |=> !ie_o);

    // R9: return always reopens the enable
    p_restore_opens_r9: assert property (@(posedge clk) disable iff (rst)
        restore_i |=> ie_o);

endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
    import irq_seq_pkg::*;
#(
    parameter int              SP_W   = 8,
    parameter logic [SP_W-1:0] SP_INIT = '0,
    parameter logic [15:0]     VECTOR = 16'hFFF0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            retire_i,
    input  logic            rti_i,
    input  logic            pending_i,
    input  logic            ie_i,
    input  logic [15:0]     pc_i,
    input  logic [7:0]      flags_i,
    input  logic [7:0]      stk_rdata_i,
    output logic            take_o,
    output logic            restore_o,
    output logic            stk_we_o,
    output logic            stk_re_o,
    output logic [SP_W-1:0] stk_addr_o,
    output logic [7:0]      stk_wdata_o,
    output logic            pc_load_o,
    output logic [15:0]     pc_value_o,
    output logic            flags_load_o,
    output logic [7:0]      flags_value_o,
    output logic            busy_o
);
    localparam logic [SP_W-1:0] SP_ONE = 1;

    seq_state_e      state_q, state_d;
    logic [SP_W-1:0] sp_q;
    cpu_ctx_t        saved_q, popped_q;
    logic            idle_w, begin_rti_w;

    assign idle_w      = (state_q == ST_IDLE);
    assign take_o      = idle_w && retire_i && pending_i && ie_i && !rti_i;
    assign begin_rti_w = idle_w && rti_i;
    assign restore_o   = (state_q == ST_RESTORE);
    assign busy_o      = !idle_w;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (begin_rti_w) state_d = ST_POP_FL;
                        else if (take_o) state_d = ST_PUSH_HI;
            ST_PUSH_HI: state_d = ST_PUSH_LO;
            ST_PUSH_LO: state_d = ST_PUSH_FL;
            ST_PUSH_FL: state_d = ST_VECTOR;
            ST_VECTOR:  state_d = ST_IDLE;
            ST_POP_FL:  state_d = ST_POP_LO;
            ST_POP_LO:  state_d = ST_POP_HI;
            ST_POP_HI:  state_d = ST_RESTORE;
            ST_RESTORE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            sp_q     <= SP_INIT;
            saved_q  <= '0;
            popped_q <= '0;
        end else begin
            state_q <= state_d;
            if (take_o) saved_q <= '{pc: pc_i, flags: flags_i};
            if (is_push(state_q)) sp_q <= sp_q - SP_ONE;
            if (is_pop(state_q))  sp_q <= sp_q + SP_ONE;
            if (state_q == ST_POP_FL) popped_q.flags    <= stk_rdata_i;
            if (state_q == ST_POP_LO) popped_q.pc[7:0]  <= stk_rdata_i;
            if (state_q == ST_POP_HI) popped_q.pc[15:8] <= stk_rdata_i;
        end
    end

    always_comb begin
        stk_we_o      = is_push(state_q);
        stk_re_o      = is_pop(state_q);
        stk_addr_o    = is_push(state_q) ? (sp_q - SP_ONE) : sp_q;
        stk_wdata_o   = '0;
        pc_load_o     = 1'b0;
        pc_value_o    = '0;
        flags_load_o  = 1'b0;
        flags_value_o = popped_q.flags;
        unique case (state_q)
            ST_PUSH_HI: stk_wdata_o = saved_q.pc[15:8];
            ST_PUSH_LO: stk_wdata_o = saved_q.pc[7:0];
            ST_PUSH_FL: stk_wdata_o = saved_q.flags;
            ST_VECTOR: begin
                pc_load_o  = 1'b1;
                pc_value_o = VECTOR;
            end
            ST_RESTORE: begin
                pc_load_o    = 1'b1;
                pc_value_o   = popped_q.pc;
                flags_load_o = 1'b1;
            end
            default: ;
        endcase
    end

    // R4, R8: the stack port never reads and writes in one cycle
    p_port_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        !(stk_we_o && stk_re_o));

    // R4: the high return byte is written in the cycle after entry
    p_first_push_r4: assert property (@(posedge clk) disable iff (rst)
        take_o |=> (stk_we_o && stk_wdata_o == $past(pc_i[15:8])));

    // R4: each write lowers the pointer by one
    p_sp_down_r4: assert property (@(posedge clk) disable iff (rst)
        stk_we_o |=> (sp_q == $past(sp_q) - SP_ONE));

    // R3: a sequence only starts on a retire or return command
    p_boundary_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> ($past(retire_i) || $past(rti_i)));

    // R5: every program-counter load ends the sequence
    p_load_ends_r5: assert property (@(posedge clk) disable iff (rst)
        pc_load_o |=> !busy_o);

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int              SYNC_STAGES = 2,
    parameter int              SP_W        = 8,
    parameter logic [SP_W-1:0] SP_INIT     = '0,
    parameter logic [15:0]     VECTOR      = 16'hFFF0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            irq_pin_i,
    input  logic            tick_i,
    input  logic            retire_i,
    input  logic            rti_i,
    input  logic            ie_set_i,
    input  logic            ie_clr_i,
    input  logic [15:0]     pc_i,
    input  logic [7:0]      flags_i,
    input  logic [7:0]      stk_rdata_i,
    output logic            stk_we_o,
    output logic            stk_re_o,
    output logic [SP_W-1:0] stk_addr_o,
    output logic [7:0]      stk_wdata_o,
    output logic            pc_load_o,
    output logic [15:0]     pc_value_o,
    output logic            flags_load_o,
    output logic [7:0]      flags_value_o,
    output logic            ie_o,
    output logic            busy_o
);
    logic rise_w, pending_w, take_w, restore_w;

    irq_req_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (irq_pin_i),
        .rise_o (rise_w)
    );

    irq_pending_ctl u_pend (
        .clk       (clk),
        .rst       (rst),
        .rise_i    (rise_w),
        .tick_i    (tick_i),
        .take_i    (take_w),
        .restore_i (restore_w),
        .ie_set_i  (ie_set_i),
        .ie_clr_i  (ie_clr_i),
        .pending_o (pending_w),
        .ie_o      (ie_o)
    );

    irq_stack_seq #(.SP_W(SP_W), .SP_INIT(SP_INIT), .VECTOR(VECTOR)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .retire_i      (retire_i),
        .rti_i         (rti_i),
        .pending_i     (pending_w),
        .ie_i          (ie_o),
        .pc_i          (pc_i),
        .flags_i       (flags_i),
        .stk_rdata_i   (stk_rdata_i),
        .take_o        (take_w),
        .restore_o     (restore_w),
        .stk_we_o      (stk_we_o),
        .stk_re_o      (stk_re_o),
        .stk_addr_o    (stk_addr_o),
        .stk_wdata_o   (stk_wdata_o),
        .pc_load_o     (pc_load_o),
        .pc_value_o    (pc_value_o),
        .flags_load_o  (flags_load_o),
        .flags_value_o (flags_value_o),
        .busy_o        (busy_o)
    );

    // R11: while busy, the enable cannot be reopened by a retire
    p_busy_masked_r11: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !pc_load_o && !ie_o && !ie_set_i) |=> !ie_o);

endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_pin_i = 0, tick_i = 0, retire_i = 0, rti_i = 0;
    logic        ie_set_i = 0, ie_clr_i = 0;
    logic [15:0] pc_i = '0;
    logic [7:0]  flags_i = '0;
    logic [7:0]  stk_rdata_i;
    logic        stk_we_o, stk_re_o, pc_load_o, flags_load_o, ie_o, busy_o;
    logic [7:0]  stk_addr_o, stk_wdata_o, flags_value_o;
    logic [15:0] pc_value_o;

    logic [7:0]  mem [0:255];
    logic [7:0]  sp_m = 8'h00;
    int          n_tests = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_entry_seq u_irq_entry_seq (
        .clk(clk), .rst(rst), .irq_pin_i(irq_pin_i), .tick_i(tick_i),
        .retire_i(retire_i), .rti_i(rti_i), .ie_set_i(ie_set_i), .ie_clr_i(ie_clr_i),
        .pc_i(pc_i), .flags_i(flags_i), .stk_rdata_i(stk_rdata_i),
        .stk_we_o(stk_we_o), .stk_re_o(stk_re_o), .stk_addr_o(stk_addr_o),
        .stk_wdata_o(stk_wdata_o), .pc_load_o(pc_load_o), .pc_value_o(pc_value_o),
        .flags_load_o(flags_load_o), .flags_value_o(flags_value_o),
        .ie_o(ie_o), .busy_o(busy_o)
    );

    assign stk_rdata_i = mem[stk_addr_o];
    always @(posedge clk) if (stk_we_o) mem[stk_addr_o] <= stk_wdata_o;

    function automatic logic [7:0] exp_push_byte(input int idx, input logic [15:0] pc,
                                                 input logic [7:0] fl);
        return (idx == 0) ? pc[15:8] : (idx == 1) ? pc[7:0] : fl;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic pulse_ie(input bit set_v, input bit clr_v);
        ie_set_i = set_v; ie_clr_i = clr_v; step(); ie_set_i = 0; ie_clr_i = 0;
    endtask

    // Entry from a pending request; optional coincident tick/set and a mid-sequence rti.
    task automatic do_entry(input logic [15:0] pc, input logic [7:0] fl,
                            input bit coinc, input bit rti_mid);
        pc_i = pc; flags_i = fl; retire_i = 1; tick_i = coinc; ie_set_i = coinc;
        step();
        retire_i = 0; tick_i = 0; ie_set_i = 0;
        chk(ie_o == 1'b0, "R6 enable after entry", ie_o, 0);
        chk(busy_o == 1'b1, "R3 busy after retire", busy_o, 1);
        for (int i = 0; i < 3; i++) begin
            if (rti_mid && i == 0) rti_i = 1;
            chk(stk_we_o && stk_addr_o == sp_m - 8'(i + 1), "R4 push addr",
                {stk_we_o, stk_addr_o}, {1'b1, 8'(sp_m - 8'(i + 1))});
            chk(stk_wdata_o == exp_push_byte(i, pc, fl), "R4 push data",
                stk_wdata_o, exp_push_byte(i, pc, fl));
            step();
            rti_i = 0;
        end
        chk(pc_load_o && pc_value_o == 16'hFFF0, "R5 vector load",
            {pc_load_o, pc_value_o}, {1'b1, 16'hFFF0});
        step();
        chk(busy_o == 1'b0, "R5 R11 idle after vector", busy_o, 0);
        sp_m = sp_m - 8'd3;
    endtask

    task automatic do_rti(input logic [15:0] pc, input logic [7:0] fl);
        rti_i = 1; step(); rti_i = 0;
        for (int i = 0; i < 3; i++) begin
            chk(stk_re_o && stk_addr_o == sp_m + 8'(i), "R8 pop addr",
                {stk_re_o, stk_addr_o}, {1'b1, 8'(sp_m + 8'(i))});
            step();
        end
        chk(pc_load_o && flags_load_o && pc_value_o == pc && flags_value_o == fl,
            "R8 restore", {pc_load_o, flags_load_o, pc_value_o, flags_value_o},
            {2'b11, pc, fl});
        step();
        chk(ie_o == 1'b1 && busy_o == 1'b0, "R9 enable after return", {ie_o, busy_o}, 2'b10);
        sp_m = sp_m + 8'd3;
    endtask

    task automatic retire_expect_idle(input string req);
        retire_i = 1; step(); retire_i = 0;
        chk(busy_o == 1'b0, req, busy_o, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R12 reset state
        chk(!busy_o && !ie_o && !stk_we_o && !stk_re_o && !pc_load_o && !flags_load_o,
            "R12 reset outputs", {busy_o, ie_o, stk_we_o, stk_re_o, pc_load_o}, 0);
        pulse_ie(1, 0);
        retire_expect_idle("R12 nothing pending after reset");

        // R1 latency: pin rises before edge 1, retire at edge 2 is too early
        irq_pin_i = 1; step();
        retire_expect_idle("R1 synchronizer latency");
        step();
        // R3: pending and enabled but no retire -> stays idle
        repeat (5) step();
        chk(busy_o == 1'b0, "R3 no entry without retire", busy_o, 0);
        do_entry(16'h1234, 8'hA5, 0, 0);   // R4 first write at 8'hFF
        do_rti(16'h1234, 8'hA5);
        // R1: level still high gives no new event
        retire_expect_idle("R1 held level no retrigger");
        irq_pin_i = 0; repeat (3) step();

        // R7: clear wins over set
        tick_i = 1; step(); tick_i = 0;
        pulse_ie(1, 1);
        chk(ie_o == 1'b0, "R7 clear wins", ie_o, 0);
        retire_expect_idle("R7 disabled blocks entry");
        pulse_ie(1, 0);
        chk(ie_o == 1'b1, "R7 set", ie_o, 1);

        // R10, R6: tick and enable-set coinciding with entry
        do_entry(16'hBEEF, 8'h3C, 1, 0);
        do_rti(16'hBEEF, 8'h3C);
        // R10: leftover request enters at once; R11: rti mid-push ignored
        do_entry(16'h0042, 8'h81, 0, 1);
        do_rti(16'h0042, 8'h81);
        retire_expect_idle("R2 request consumed");

        // random rounds, R2 sources alternate
        for (int n = 0; n < 24; n++) begin
            logic [15:0] pc_r;
            logic [7:0]  fl_r;
            pc_r = 16'($urandom);
            fl_r = 8'($urandom);
            if ($urandom % 2 == 0) begin
                irq_pin_i = 1; repeat (4) step(); irq_pin_i = 0;
            end else begin
                tick_i = 1; step(); tick_i = 0;
            end
            repeat ($urandom % 4) step();
            do_entry(pc_r, fl_r, 0, 0);
            repeat ($urandom % 3) step();
            do_rti(pc_r, fl_r);
            repeat (3) step();
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule